// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block tracks the tags of a set-associative data cache and decides, for every access, whether it hits or misses. It holds no cache data. An access carries a 32-bit byte address and a kind: load, store or swap. One cycle after the block accepts an access, it reports four things: hit or miss, the set (row) that was indexed, the way that matched or was chosen as the victim, and the number of stall cycles the access costs.

Loads that miss refill a victim way with the new line. Stores that miss allocate nothing. A swap is a load lookup followed at once by a store lookup to the same line, and both happen in a single accepted access. The victim comes from one of two policies, chosen by a pin:
- a per-row rotating pointer, or
- one pointer shared by all rows that makes an extra step on every thirteenth replacement.

Four saturating event counters can be read through a select port. After reset the block walks through every row to invalidate it, and it holds ready low until that walk is done.

Top module: `cache_tag_model`

## Requirements
- R1: After reset, req_ready_o stays low for exactly ROWS cycles (128 by default) while all tags and per-row pointers are cleared, then stays high. rsp_valid_o is low and all counters read zero.
- R2: With default geometry, rsp_row_o equals address bits [11:5]. The line address is the byte address shifted right by 5, and the row is its low 7 bits.
- R3: An access hits when a way of the indexed row holds the same line address, whatever the byte offset within the line. A hit reports rsp_hit_o=1, the matching way and a stall of 0.
- R4: A load miss reports a stall of 30 and writes the line address into the victim way, so the next load to that line hits.
- R5: A store miss reports a stall of 5 and leaves every tag unchanged, so a later load to that line still misses.
- R6: With policy_i=0, each row has its own victim pointer. It starts at way 0 and steps by one per load miss in that row, wrapping at the way count.
- R7: With policy_i=1, one global pointer supplies the victim and steps by one with wrap. On every 13th replacement under this policy it steps one extra position. Neither policy's state moves while the other policy is selected.
- R8: A swap (req_op_i 2'b10 or 2'b11) acts as a load lookup, including any refill, followed by a store lookup of the same line. It reports the load outcome and the load stall (30 on a miss, 0 on a hit), and its store part always counts as a store hit.
- R9: rsp_valid_o pulses exactly one cycle after each accepted request (req_valid_i and req_ready_o both high). A request in the very next cycle sees the refill made by the previous one.
- R10: stat_data_o shows the counter picked by stat_sel_i: 0 = load hits, 1 = load misses, 2 = store hits, 3 = store misses. Each counter adds one per event and never decreases.
- R11: A reset tag never matches any address, including the top line whose line address is all ones (byte address 0xFFFFFFE0).
- R12: Access kinds use req_op_i 2'b00 for load and 2'b01 for store; both values with the top bit set mean swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | Victim policy: 0 per-row rotation, 1 global rotation with skip |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | 32 | Byte address |
| req_op_i | input | 2 | Access kind (R12) |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Load part (or store) hit |
| rsp_row_o | output | 7 | Indexed row |
| rsp_way_o | output | 2 | Matching way on hit, victim way on miss |
| rsp_stall_o | output | 8 | Stall cycles charged |
| stat_sel_i | input | 2 | Counter select |
| stat_data_o | output | 64 | Selected counter value |

## Verification
Two pieces of work can fall in the same cycle. The first is the refill made by a missing load. The second is either the store lookup that follows it inside a swap, or the lookup of the next request when requests arrive back to back. Both are driven on purpose: a swap to a fresh line, and a miss followed with no idle cycle by a second load to the same line. The result is judged at the ports. A swap that misses must still add a store hit, and the trailing load must come back as a hit on the way that was just refilled. Counter values read afterwards confirm that each event was counted exactly once.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_SWAP2 = 2'b11
  } op_e;

  localparam int unsigned N_STAT  = 4;
  localparam int unsigned ST_LHIT = 0;
  localparam int unsigned ST_LMIS = 1;
  localparam int unsigned ST_SHIT = 2;
  localparam int unsigned ST_SMIS = 3;
endpackage

// File: rtl/ctm_tag_store.sv
module ctm_tag_store #(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 27,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] clr_row_i,
  input  logic [ROW_W-1:0] lk_row_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o
);
  // one spare bit: invalid is all ones across TAG_W+1, never equal to a line address
  logic [TAG_W:0] mem [ROWS][WAYS];
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (mem[lk_row_i][w] == {1'b0, lk_tag_i});
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      for (int w = 0; w < WAYS; w++) mem[clr_row_i][w] <= '1;
    end else if (wr_i) begin
      mem[wr_row_i][wr_way_i] <= {1'b0, wr_tag_i};
    end
  end
endmodule

// File: rtl/ctm_victim.sv
module ctm_victim #(
  parameter int unsigned ROWS = 128,
  parameter int unsigned WAYS = 4,
  parameter int unsigned SKIP = 13,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SKIP_W = $clog2(SKIP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] clr_row_i,
  input  logic             policy_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o
);
  function automatic logic [WAY_W-1:0] step(input logic [WAY_W-1:0] p);
    return (p == WAY_W'(WAYS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WAY_W-1:0]  rr_ptr [ROWS];
  logic [WAY_W-1:0]  g_ptr;
  logic [SKIP_W-1:0] g_cnt;
  logic [WAY_W-1:0]  g_nxt;
  logic              g_wrap;

  assign way_o  = policy_i ? g_ptr : rr_ptr[row_i];
  assign g_nxt  = step(g_ptr);
  assign g_wrap = (g_cnt == SKIP_W'(SKIP - 1));

  always_ff @(posedge clk_i) begin
    if (clr_i) rr_ptr[clr_row_i] <= '0;
    else if (adv_i && !policy_i) rr_ptr[row_i] <= step(rr_ptr[row_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_ptr <= '0;
      g_cnt <= '0;
    end else if (adv_i && policy_i) begin
      if (g_wrap) begin
        g_cnt <= '0;
        g_ptr <= step(g_nxt);
      end else begin
        g_cnt <= g_cnt + 1'b1;
        g_ptr <= g_nxt;
      end
    end
  end
endmodule

// File: rtl/ctm_stats.sv
module ctm_stats #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned N     = 4,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     inc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] data_o
);
  logic [CNT_W-1:0] cnt [N];

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt[i] <= '0;
      else if (inc_i[i] && !(&cnt[i])) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  assign data_o = cnt[sel_i];
endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SIZE_BYTES = 16384,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned LOAD_PEN   = 30,
  parameter int unsigned STORE_PEN  = 5,
  parameter int unsigned SKIP       = 13,
  parameter int unsigned STALL_W    = 8,
  parameter int unsigned CNT_W      = 64,
  localparam int unsigned ROWS  = SIZE_BYTES / (LINE_BYTES * WAYS),
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned TAG_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               policy_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_op_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [ROW_W-1:0]   rsp_row_o,
  output logic [WAY_W-1:0]   rsp_way_o,
  output logic [STALL_W-1:0] rsp_stall_o,
  input  logic [1:0]         stat_sel_i,
  output logic [CNT_W-1:0]   stat_data_o
);
  import ctm_pkg::*;

  logic             busy_q;
  logic [ROW_W-1:0] sweep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == ROW_W'(ROWS - 1)) busy_q <= 1'b0;
    end
  end
  assign req_ready_o = !busy_q;

  logic [TAG_W-1:0] line;
  logic [ROW_W-1:0] row;
  logic             accept, is_store, is_swap, has_load;
  logic             hit, alloc;
  logic [WAY_W-1:0] hit_way, victim;

  assign line     = req_addr_i[ADDR_W-1:OFF_W];
  assign row      = line[ROW_W-1:0];
  assign accept   = req_valid_i && req_ready_o;
  assign is_store = (req_op_i == OP_STORE);
  assign is_swap  = req_op_i[1];
  assign has_load = !is_store;
  assign alloc    = accept && has_load && !hit;

  ctm_tag_store #(.ROWS(ROWS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .clr_i     (busy_q),
    .clr_row_i (sweep_q),
    .lk_row_i  (row),
    .lk_tag_i  (line),
    .wr_i      (alloc),
    .wr_row_i  (row),
    .wr_way_i  (victim),
    .wr_tag_i  (line),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  ctm_victim #(.ROWS(ROWS), .WAYS(WAYS), .SKIP(SKIP)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (busy_q),
    .clr_row_i (sweep_q),
    .policy_i  (policy_i),
    .row_i     (row),
    .adv_i     (alloc),
    .way_o     (victim)
  );

  logic [N_STAT-1:0] inc;
  always_comb begin
    inc          = '0;
    inc[ST_LHIT] = accept && has_load && hit;
    inc[ST_LMIS] = alloc;
    // swap: the store part follows the load refill, so it always hits
    inc[ST_SHIT] = accept && (is_swap || (is_store && hit));
    inc[ST_SMIS] = accept && is_store && !hit;
  end

  ctm_stats #(.CNT_W(CNT_W), .N(N_STAT)) u_stats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc),
    .sel_i  (stat_sel_i),
    .data_o (stat_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_row_o   <= '0;
      rsp_way_o   <= '0;
      rsp_stall_o <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_hit_o   <= hit;
        rsp_row_o   <= row;
        rsp_way_o   <= hit ? hit_way : victim;
        rsp_stall_o <= hit ? '0 : (is_store ? STALL_W'(STORE_PEN) : STALL_W'(LOAD_PEN));
      end
    end
  end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ROWS      = 128,
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned ROW_W     = 7,
  parameter int unsigned STALL_W   = 8,
  parameter int unsigned LOAD_PEN  = 30,
  parameter int unsigned STORE_PEN = 5,
  parameter int unsigned CNT_W     = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [1:0]         req_op_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic [ROW_W-1:0]   rsp_row_o,
  input logic [STALL_W-1:0] rsp_stall_o,
  input logic [1:0]         stat_sel_i,
  input logic [CNT_W-1:0]   stat_data_o
);
  localparam int unsigned IC_W = $clog2(ROWS + 1);
  logic [IC_W-1:0] init_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_cnt <= '0;
    else if (init_cnt != IC_W'(ROWS)) init_cnt <= init_cnt + 1'b1;
  end

  a_r1_init_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_cnt < IC_W'(ROWS)) |-> !req_ready_o);
  a_r1_ready_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_cnt == IC_W'(ROWS)) |-> req_ready_o);
  a_r9_rsp_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i && req_ready_o));
  a_r2_row_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_row_o == $past(req_addr_i[OFF_W+ROW_W-1:OFF_W]));
  a_r3_hit_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> rsp_stall_o == '0);
  a_r4_load_miss_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o && $past(req_op_i) != 2'b01) |-> rsp_stall_o == STALL_W'(LOAD_PEN));
  a_r5_store_miss_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o && $past(req_op_i) == 2'b01) |-> rsp_stall_o == STALL_W'(STORE_PEN));
  a_r10_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(stat_sel_i) |-> stat_data_o >= $past(stat_data_o));
endmodule

bind cache_tag_model ctm_checker #(
  .ADDR_W(ADDR_W), .ROWS(ROWS), .OFF_W(OFF_W), .ROW_W(ROW_W), .STALL_W(STALL_W),
  .LOAD_PEN(LOAD_PEN), .STORE_PEN(STORE_PEN), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_addr_i(req_addr_i), .req_op_i(req_op_i), .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o(rsp_hit_o), .rsp_row_o(rsp_row_o), .rsp_stall_o(rsp_stall_o),
  .stat_sel_i(stat_sel_i), .stat_data_o(stat_data_o)
);

// File: tb/cache_tag_model_test.sv
module cache_tag_model_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        policy_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_op_i = 2'b00;
  logic        rsp_valid_o, rsp_hit_o;
  logic [6:0]  rsp_row_o;
  logic [1:0]  rsp_way_o;
  logic [7:0]  rsp_stall_o;
  logic [1:0]  stat_sel_i = '0;
  logic [63:0] stat_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  longint e_lh = 0, e_lm = 0, e_sh = 0, e_sm = 0;

  always #5 clk_i = ~clk_i;

  cache_tag_model uut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int hi, int row, int off);
    return (32'(hi) << 12) | (32'(row) << 5) | 32'(off);
  endfunction

  // issue one access, check one-cycle response
  task automatic acc(string req, logic [1:0] op, logic [31:0] a,
                     bit exp_hit, int exp_way, int exp_stall);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_op_i = op;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({req, " rsp_valid (R9)"}, rsp_valid_o, 1);
    chk({req, " hit"}, rsp_hit_o, exp_hit);
    chk({req, " way"}, rsp_way_o, exp_way);
    chk({req, " stall"}, rsp_stall_o, exp_stall);
    chk({req, " row (R2)"}, rsp_row_o, (a >> 5) & 127);
  endtask

  task automatic t_reset;
    int low = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 ready low after reset", req_ready_o, 0);
    chk("R1 rsp_valid low", rsp_valid_o, 0);
    for (int s = 0; s < 4; s++) begin
      stat_sel_i = 2'(s); #1;
      chk("R1 counter zero", stat_data_o, 0);
    end
    while (!req_ready_o && low < 1000) begin
      low++;
      @(negedge clk_i);
    end
    chk("R1 init length", low, 128);
  endtask

  task automatic t_load_basic;
    acc("R4 load miss", 2'b00, mk(1, 3, 0), 0, 0, 30);
    acc("R3 load hit other offset", 2'b00, mk(1, 3, 7), 1, 0, 0);
    e_lm++; e_lh++;
  endtask

  task automatic t_store;
    acc("R5 store miss", 2'b01, mk(2, 9, 4), 0, 0, 5);
    acc("R5 no allocate, load misses", 2'b00, mk(2, 9, 4), 0, 0, 30);
    acc("R3 store hit", 2'b01, mk(2, 9, 0), 1, 0, 0);
    e_sm++; e_lm++; e_sh++;
  endtask

  task automatic t_rr;
    for (int i = 1; i <= 5; i++) acc("R6 row rotation", 2'b00, mk(i, 20, 0), 0, (i - 1) % 4, 30);
    acc("R6 evicted line misses", 2'b00, mk(1, 20, 0), 0, 1, 30);
    acc("R6 kept line hits", 2'b00, mk(3, 20, 0), 1, 2, 0);
    acc("R6 other row own pointer", 2'b00, mk(1, 21, 0), 0, 0, 30);
    e_lm += 7; e_lh++;
  endtask

  task automatic t_back2back;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = mk(1, 30, 0); req_op_i = 2'b00;
    @(negedge clk_i);
    chk("R9 first rsp", rsp_valid_o, 1);
    chk("R4 first miss", rsp_hit_o, 0);
    req_addr_i = mk(1, 30, 12);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R9 second rsp", rsp_valid_o, 1);
    chk("R9 back-to-back sees refill", rsp_hit_o, 1);
    chk("R9 refilled way", rsp_way_o, 0);
    @(negedge clk_i);
    chk("R9 no rsp when idle", rsp_valid_o, 0);
    e_lm++; e_lh++;
  endtask

  task automatic t_swap;
    acc("R8 swap miss", 2'b10, mk(1, 40, 0), 0, 0, 30);
    acc("R8 swap allocated", 2'b00, mk(1, 40, 0), 1, 0, 0);
    acc("R12 swap alt code hit", 2'b11, mk(1, 40, 0), 1, 0, 0);
    e_lm++; e_sh++; e_lh++; e_lh++; e_sh++;
  endtask

  task automatic t_invalid;
    acc("R11 top line misses", 2'b00, 32'hFFFF_FFE0, 0, 0, 30);
    acc("R11 top line then hits", 2'b00, 32'hFFFF_FFE4, 1, 0, 0);
    e_lm++; e_lh++;
  endtask

  task automatic t_rotate;
    int ptr = 0, cnt = 0, w;
    policy_i = 1'b1;
    for (int i = 0; i < 15; i++) begin
      w = ptr;
      ptr = (ptr + 1) % 4;
      cnt++;
      if (cnt == 13) begin cnt = 0; ptr = (ptr + 1) % 4; end
      acc("R7 global victim", 2'b00, mk(1, 50 + i, 0), 0, w, 30);
    end
    policy_i = 1'b0;
    acc("R7 row pointer untouched", 2'b00, mk(7, 20, 0), 0, 2, 30);
    e_lm += 16;
  endtask

  task automatic t_stats;
    @(negedge clk_i);
    stat_sel_i = 2'd0; #1; chk("R10 load hits", stat_data_o, e_lh);
    stat_sel_i = 2'd1; #1; chk("R10 load misses", stat_data_o, e_lm);
    stat_sel_i = 2'd2; #1; chk("R10 store hits", stat_data_o, e_sh);
    stat_sel_i = 2'd3; #1; chk("R10 store misses", stat_data_o, e_sm);
  endtask

  initial begin
    t_reset();
    t_load_basic();
    t_store();
    t_rr();
    t_back2back();
    t_swap();
    t_invalid();
    t_rotate();
    t_stats();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule